// File: doc/BRIEF.md
# Debounced Level Interrupt Bank

This block watches a group of external input pins, filters each through its own
millisecond-resolution debounce counter, and turns the filtered level into an
interrupt request. Software programs a debounce time per channel, chooses
whether each channel fires on a high or a low level, and reads both the filtered
pin value and the interrupt status through a small 32-bit register port.

Each channel fires at most once per arming. A per-channel arm bit must be set by
software before a matching level can latch the raw status. When the status
latches, the hardware clears the arm bit. A held level therefore does not keep
re-asserting the status after software clears it. All masked status bits are
ORed onto one interrupt line.

The millisecond tick is a one-cycle strobe made outside the block. A channel
whose enable bit is 0 holds its filtered value at 0 and can never raise status.

Top module: `deb_irq_bank`

## Requirements
- R1: After reset every readable register returns 0 and `irq` is 0.
- R2: With its enable bit at 1, a channel's filtered data bit (offset 0x00, bit n for channel n) takes the new pin value once the pin, after a two-flop synchronizer, has differed from it on L consecutive tick strobes. L is bits [11:0] of the channel control register at 0x40 + 4·n, and a programmed 0 counts as 1.
- R3: If the synchronized pin returns to the filtered value before L ticks have elapsed, the count restarts and the filtered value does not change.
- R4: A channel whose bit in the enable mask (0x04) is 0 reads 0 in the data register and never sets its raw status bit.
- R5: The polarity register (0x14) selects the active level per channel: 1 means filtered data 1 is active, and 0 means filtered data 0 is active.
- R6: Raw status (0x1C) bit n sets only while arm bit n (0x28) is 1 and channel n is enabled and at its active level. In the same cycle that the status sets, the arm bit returns to 0. A software write of 1 re-arms the channel.
- R7: Writing the clear register (0x24) clears each raw status bit written as 1 and leaves bits written as 0 unchanged. The clear register reads 0.
- R8: Masked status (0x20) equals raw status AND interrupt enable (0x18), and `irq` is 1 exactly when any masked bit is 1.
- R9: The control registers keep only bits [11:0]; the upper bits read 0.
- R10: The enable, polarity, interrupt-enable and arm registers keep bits [7:0] as written and read 0 above them.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Write strobe for the register port |
| reg_addr | input | 8 | Byte address of the register |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr`, combinational |
| pin_in | input | 8 | Raw asynchronous external inputs |
| ms_tick | input | 1 | One-cycle millisecond strobe |
| irq | output | 1 | OR of all masked status bits |

## Verification
A debounce counter that counts wrongly shows up in the data register as a change one tick early or one tick late. It also shows up as a glitch being let through. The bench therefore reads the data register on both sides of the Lth tick for every channel. A fault in the arm or status state shows up in the raw-status and arm registers one cycle after the level matches. It appears as a repeated trigger while the level is held, or as a status that never latches. The line `irq` and the masked register expose a wrong enable gating as soon as the status settles.

// File: rtl/dirq_pkg.sv
package dirq_pkg;
    // Register byte offsets; software decodes these, so they are fixed.
    localparam int OFS_DATA = 'h00;
    localparam int OFS_EN   = 'h04;
    localparam int OFS_POL  = 'h14;
    localparam int OFS_IE   = 'h18;
    localparam int OFS_RAW  = 'h1C;
    localparam int OFS_MIS  = 'h20;
    localparam int OFS_CLR  = 'h24;
    localparam int OFS_ARM  = 'h28;
    localparam int OFS_CTL  = 'h40;
    localparam int CTL_STEP = 4;
endpackage

// File: rtl/dirq_sync.sv
module dirq_sync #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);
    typedef struct packed {
        logic [W-1:0] s1;
        logic [W-1:0] s2;
    } sync_t;

    sync_t sy_d, sy_q;

    always_comb begin
        sy_d    = sy_q;
        sy_d.s1 = din;
        sy_d.s2 = sy_q.s1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sy_q <= '0;
        else        sy_q <= sy_d;
    end

    assign dout = sy_q.s2;
endmodule

// File: rtl/dirq_debounce.sv
module dirq_debounce #(
    parameter int CNT_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic             tick,
    input  logic             din,
    input  logic [CNT_W-1:0] limit,
    output logic             stable
);
    typedef struct packed {
        logic             stable;
        logic [CNT_W-1:0] cnt;
    } db_t;

    db_t db_d, db_q;
    logic [CNT_W:0] lim_eff;
    logic [CNT_W:0] cnt_nx;

    always_comb begin
        lim_eff = (limit == '0) ? (CNT_W+1)'(1) : {1'b0, limit};
        cnt_nx  = {1'b0, db_q.cnt} + (CNT_W+1)'(1);
        db_d    = db_q;
        if (!en) begin
            db_d = '0;
        end else if (din == db_q.stable) begin
            db_d.cnt = '0;
        end else if (tick) begin
            if (cnt_nx >= lim_eff) begin
                db_d.stable = din;
                db_d.cnt    = '0;
            end else begin
                db_d.cnt = cnt_nx[CNT_W-1:0];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) db_q <= '0;
        else        db_q <= db_d;
    end

    assign stable = db_q.stable;

    // R2
    stable_on_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(en) && (db_q.stable != $past(db_q.stable))) |-> $past(tick));

    // R3
    count_needs_diff_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (db_q.cnt != '0) |-> ($past(din) != $past(db_q.stable)));

    // R4
    idle_when_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(en) |-> (db_q.stable == 1'b0 && db_q.cnt == '0));
endmodule

// File: rtl/dirq_regs.sv
module dirq_regs
    import dirq_pkg::*;
#(
    parameter int NCH   = 8,
    parameter int CNT_W = 12,
    parameter int AW    = 8,
    parameter int DW    = 32
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      wr,
    input  logic [AW-1:0]             addr,
    input  logic [DW-1:0]             wdata,
    output logic [DW-1:0]             rdata,
    input  logic [NCH-1:0]            stable,
    output logic [NCH-1:0]            en_mask,
    output logic [NCH-1:0][CNT_W-1:0] limit,
    output logic                      irq
);
    typedef struct packed {
        logic [NCH-1:0]            en;
        logic [NCH-1:0]            pol;
        logic [NCH-1:0]            ie;
        logic [NCH-1:0]            arm;
        logic [NCH-1:0]            raw;
        logic [NCH-1:0][CNT_W-1:0] ctl;
    } rf_t;

    rf_t rf_d, rf_q;
    logic [NCH-1:0] clr;
    logic [NCH-1:0] hit;
    logic [NCH-1:0] set;
    logic [NCH-1:0] mis;

    always_comb begin
        rf_d = rf_q;
        clr  = '0;
        if (wr) begin
            unique case (addr)
                AW'(OFS_EN):  rf_d.en  = wdata[NCH-1:0];
                AW'(OFS_POL): rf_d.pol = wdata[NCH-1:0];
                AW'(OFS_IE):  rf_d.ie  = wdata[NCH-1:0];
                AW'(OFS_CLR): clr      = wdata[NCH-1:0];
                AW'(OFS_ARM): rf_d.arm = wdata[NCH-1:0];
                default: begin
                    for (int i = 0; i < NCH; i++) begin
                        if (addr == AW'(OFS_CTL + CTL_STEP*i))
                            rf_d.ctl[i] = wdata[CNT_W-1:0];
                    end
                end
            endcase
        end
        hit      = rf_q.en & ~(stable ^ rf_q.pol);
        set      = hit & rf_q.arm;
        rf_d.raw = (rf_q.raw & ~clr) | set;
        rf_d.arm = rf_d.arm & ~set;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rf_q <= '0;
        else        rf_q <= rf_d;
    end

    assign mis = rf_q.raw & rf_q.ie;

    always_comb begin
        rdata = '0;
        unique case (addr)
            AW'(OFS_DATA): rdata = DW'(stable);
            AW'(OFS_EN):   rdata = DW'(rf_q.en);
            AW'(OFS_POL):  rdata = DW'(rf_q.pol);
            AW'(OFS_IE):   rdata = DW'(rf_q.ie);
            AW'(OFS_RAW):  rdata = DW'(rf_q.raw);
            AW'(OFS_MIS):  rdata = DW'(mis);
            AW'(OFS_ARM):  rdata = DW'(rf_q.arm);
            default: begin
                for (int i = 0; i < NCH; i++) begin
                    if (addr == AW'(OFS_CTL + CTL_STEP*i))
                        rdata = DW'(rf_q.ctl[i]);
                end
            end
        endcase
    end

    assign en_mask = rf_q.en;
    assign limit   = rf_q.ctl;
    assign irq     = |mis;

    // R6
    arm_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((rf_q.raw & ~$past(rf_q.raw)) & ~$past(rf_q.arm)) == '0);

    // R6
    arm_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((rf_q.raw & ~$past(rf_q.raw)) & rf_q.arm) == '0);

    // R4
    off_no_status_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((rf_q.raw & ~$past(rf_q.raw)) & ~$past(rf_q.en)) == '0);

    // R7
    clear_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((~rf_q.raw & $past(rf_q.raw)) & ~($past(wr) ? $past(wdata[NCH-1:0]) : '0)) == '0);
endmodule

// File: rtl/deb_irq_bank.sv
module deb_irq_bank #(
    parameter int NCH   = 8,
    parameter int CNT_W = 12,
    parameter int AW    = 8,
    parameter int DW    = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          reg_wr,
    input  logic [AW-1:0] reg_addr,
    input  logic [DW-1:0] reg_wdata,
    output logic [DW-1:0] reg_rdata,
    input  logic [NCH-1:0] pin_in,
    input  logic          ms_tick,
    output logic          irq
);
    logic [NCH-1:0]            pin_s;
    logic [NCH-1:0]            stable;
    logic [NCH-1:0]            en_mask;
    logic [NCH-1:0][CNT_W-1:0] limit;

    dirq_sync #(.W(NCH)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .din   (pin_in),
        .dout  (pin_s)
    );

    for (genvar g = 0; g < NCH; g++) begin : g_ch
        dirq_debounce #(.CNT_W(CNT_W)) u_db (
            .clk    (clk),
            .rst_n  (rst_n),
            .en     (en_mask[g]),
            .tick   (ms_tick),
            .din    (pin_s[g]),
            .limit  (limit[g]),
            .stable (stable[g])
        );
    end

    dirq_regs #(.NCH(NCH), .CNT_W(CNT_W), .AW(AW), .DW(DW)) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr      (reg_wr),
        .addr    (reg_addr),
        .wdata   (reg_wdata),
        .rdata   (reg_rdata),
        .stable  (stable),
        .en_mask (en_mask),
        .limit   (limit),
        .irq     (irq)
    );

    // R8
    irq_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (en_mask != '0 || $past(en_mask) != '0 || $past(irq)));
endmodule

// File: tb/sim_deb_irq_bank.sv
module sim_deb_irq_bank;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic [7:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic [7:0]  pin_in = '0;
    logic        ms_tick = 1'b0;
    logic        irq;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #2.5 clk = ~clk;

    deb_irq_bank u0 (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .pin_in(pin_in),
        .ms_tick(ms_tick), .irq(irq)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] v);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = v;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] v);
        @(negedge clk);
        reg_addr = a;
        #1 v = reg_rdata;
    endtask

    task automatic idle(input int n);
        for (int k = 0; k < n; k++) @(negedge clk);
    endtask

    task automatic ticks(input int n);
        for (int k = 0; k < n; k++) begin
            @(negedge clk); ms_tick = 1'b1;
            @(negedge clk); ms_tick = 1'b0;
        end
    endtask

    task automatic set_pins(input logic [7:0] p);
        @(negedge clk); pin_in = p;
        idle(3);
    endtask

    task automatic rchk(input string req, input logic [7:0] a, input logic [31:0] exp);
        logic [31:0] v;
        rd(a, v);
        chk(req, v, exp);
    endtask

    initial begin
        #400000;
        if (!done) begin
            n_bad++;
            n_chk++;
            $display("FAIL watchdog: actual hung expected done");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        logic [7:0] exp_data;
        idle(3);
        rst_n = 1'b1;
        idle(1);

        // R1 reset state
        foreach (u0.u_regs.rdata[i]) begin end
        rchk("R1 data", 8'h00, 0);
        rchk("R1 en", 8'h04, 0);
        rchk("R1 pol", 8'h14, 0);
        rchk("R1 ie", 8'h18, 0);
        rchk("R1 raw", 8'h1C, 0);
        rchk("R1 mis", 8'h20, 0);
        rchk("R1 arm", 8'h28, 0);
        rchk("R1 ctl0", 8'h40, 0);
        chk("R1 irq", 32'(irq), 0);

        // R9 control field width, every channel
        for (int i = 0; i < 8; i++) begin
            wr(8'(8'h40 + 4*i), 32'hA5A5_0000 | 32'(i*517 + 3));
            rchk("R9 ctl", 8'(8'h40 + 4*i), 32'(((i*517 + 3)) & 12'hFFF));
        end
        // R10 field widths of the 8-bit registers
        wr(8'h04, 32'hFFFF_FF5A); rchk("R10 en", 8'h04, 32'h5A);
        wr(8'h14, 32'h1234_56C3); rchk("R10 pol", 8'h14, 32'hC3);
        wr(8'h18, 32'h8000_0081); rchk("R10 ie", 8'h18, 32'h81);
        wr(8'h04, 0); wr(8'h14, 0); wr(8'h18, 0);
        rchk("R7 clr reads 0", 8'h24, 0);

        // R2 debounce sweep: channel i uses L = i (0 acts as 1)
        for (int i = 0; i < 8; i++) wr(8'(8'h40 + 4*i), 32'(i));
        wr(8'h04, 32'hFF);
        for (int i = 0; i < 8; i++) begin
            int l;
            l = (i == 0) ? 1 : i;
            set_pins(8'(1 << i));
            if (l > 1) begin
                ticks(l - 1);
                rchk("R2 before L rise", 8'h00, 0);
            end
            ticks(1);
            rchk("R2 at L rise", 8'h00, 32'(1 << i));
            set_pins(8'h00);
            if (l > 1) begin
                ticks(l - 1);
                rchk("R2 before L fall", 8'h00, 32'(1 << i));
            end
            ticks(1);
            rchk("R2 at L fall", 8'h00, 0);
        end

        // R3 glitch restarts the count (channel 3, L = 3)
        set_pins(8'h08); ticks(2);
        set_pins(8'h00); ticks(1);
        rchk("R3 glitch held", 8'h00, 0);
        set_pins(8'h08); ticks(2);
        rchk("R3 restart", 8'h00, 0);
        ticks(1);
        rchk("R3 settle", 8'h00, 32'h08);
        set_pins(8'h00); ticks(3);
        rchk("R3 back", 8'h00, 0);

        // R4 disabled channel 0: data stays 0, raw never sets
        wr(8'h04, 32'hFE);
        wr(8'h14, 32'h01);
        set_pins(8'h01); ticks(4);
        rchk("R4 data off", 8'h00, 0);
        wr(8'h28, 32'h01); idle(2);
        rchk("R4 raw off", 8'h1C, 0);
        rchk("R4 arm kept", 8'h28, 32'h01);
        wr(8'h28, 0);
        set_pins(8'h00);
        wr(8'h04, 32'hFF); idle(2);

        // R5/R6 active-high on all channels, inputs low: nothing fires
        wr(8'h14, 32'hFF);
        wr(8'h18, 32'hFF);
        wr(8'h28, 32'hFF); idle(2);
        rchk("R5 high inactive", 8'h1C, 0);
        rchk("R6 arm held", 8'h28, 32'hFF);
        // channel 2 rises (L = 2)
        set_pins(8'h04); ticks(2); idle(2);
        rchk("R5 high fires", 8'h1C, 32'h04);
        rchk("R6 arm auto clear", 8'h28, 32'hFB);
        chk("R8 irq set", 32'(irq), 1);
        // channel 0 active-low while its input is low
        wr(8'h14, 32'hFE); idle(2);
        rchk("R5 low fires", 8'h1C, 32'h05);
        rchk("R6 arm clear ch0", 8'h28, 32'hFA);

        // R7 write-one-to-clear
        wr(8'h24, 32'h00); idle(2);
        rchk("R7 zero write", 8'h1C, 32'h05);
        wr(8'h24, 32'h01); idle(2);
        rchk("R7 clear ch0", 8'h1C, 32'h04);
        idle(4);
        rchk("R6 no retrigger", 8'h1C, 32'h04);
        wr(8'h28, 32'h01); idle(2);
        rchk("R6 rearm fires", 8'h1C, 32'h05);

        // R8 masked status under each single enable bit
        for (int i = 0; i < 8; i++) begin
            logic [7:0] m;
            m = 8'(1 << i);
            wr(8'h18, 32'(m)); idle(1);
            exp_data = m & 8'h05;
            rchk("R8 mis", 8'h20, 32'(exp_data));
            chk("R8 irq", 32'(irq), 32'(exp_data != 0));
        end
        wr(8'h18, 0); idle(1);
        chk("R8 irq off", 32'(irq), 0);
        wr(8'h24, 32'h05); idle(2);
        rchk("R7 clear both", 8'h1C, 0);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
        $finish;
    end
endmodule